// File: doc/BRIEF.md
# Processor Power-Mode Sequencer

This block moves a processor core between full power and three reduced-power states: doze, nap and sleep. Software chooses the target state beforehand by writing a mode field in a configuration register. Setting a separate power-enable bit then starts entry. Doze is entered at once. Nap waits until no bus operation is outstanding. Sleep also waits for the bus to drain, and then runs a two-wire handshake with the system. The block raises a quiesce request to say that it is ready to stop snooping. It waits for the quiesce acknowledge, lets a short settle interval run, and only then gates every clock.

An external interrupt or a system-management interrupt returns the core to full power. When the phase-locked loop was stopped during sleep, the block ignores the wake event until the loop reports lock. On leaving sleep, permission to re-enable the L2 cache stays withheld until a DLL relock interval of 640 cycles has run out. A 2-bit status code reports the current state.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and after it is released with idle inputs, mode_code is 00, quiesce_req is 0, unit_clk_en and tb_clk_en are 1, and l2_en_ok is 1.
- R2: The mode field is decoded from cfg_reg bit 8 (doze), bit 9 (nap) and bit 10 (sleep). A mode is selected only when its own bit is the only one of the three that is set. Any other combination selects nothing and causes no entry. The other bits of cfg_reg have no effect.
- R3: No power-down state is entered while pwr_en is 0, whatever the mode field holds.
- R4: Nap and sleep entry wait while bus_busy is 1, and quiesce_req never rises in a cycle that follows one with bus_busy high. Doze entry does not wait for the bus.
- R5: Sleep entry raises quiesce_req while mode_code stays 00, and holds it until quiesce_ack arrives. quiesce_req is high in the handshake, settle and sleep states only.
- R6: The cycle after quiesce_ack is sampled begins a settle interval of ENTRY_DLY cycles (default 4) with mode_code 00. mode_code becomes 11 on the edge that ends the interval.
- R7: Clock enables follow the state. In full power (including handshake and settle) both unit_clk_en and tb_clk_en are 1. In doze and nap, unit_clk_en is 0 and tb_clk_en is 1. In sleep both are 0.
- R8: ext_irq or smi_irq returns doze, nap or sleep to full power on the next edge and drops quiesce_req.
- R9: In sleep with pll_stopped at 1, a wake event is ignored until pll_locked is 1.
- R10: l2_en_ok is 0 in sleep. On leaving sleep it stays 0 for RELOCK_CYC cycles (default 640) and then returns to 1.
- R11: A wake event during the handshake or the settle interval aborts entry and returns to full power, even in the same cycle as quiesce_ack. In full power a wake event takes priority over pwr_en.
- R12: mode_code encodes the state: 00 full power, 01 doze, 10 nap, 11 sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reg | input | 16 | Configuration register; mode field in bits 10:8 |
| pwr_en | input | 1 | Power-down enable; starts entry into the selected mode |
| bus_busy | input | 1 | An outstanding bus operation exists |
| quiesce_ack | input | 1 | System acknowledges that snooping may stop |
| ext_irq | input | 1 | External interrupt wake event |
| smi_irq | input | 1 | System-management interrupt wake event |
| pll_stopped | input | 1 | The PLL was stopped during sleep |
| pll_locked | input | 1 | The PLL reports lock |
| quiesce_req | output | 1 | Ready to stop snooping; handshake request |
| unit_clk_en | output | 1 | Clock enable for the functional units and snooping |
| tb_clk_en | output | 1 | Clock enable for the time base and decrementer |
| l2_en_ok | output | 1 | L2 cache may be re-enabled |
| mode_code | output | 2 | Current power state code |

## Verification
Two functions can fall in the same cycle: a wake event arriving with quiesce_ack while the handshake is pending, and a wake event arriving with pwr_en while the block is at full power. In both cases the wake event must win. The bench drives each pair on the same edge, and also a wake event part way through the settle interval. A cycle-by-cycle behavioural model in the bench predicts every output on every clock, and directed checks confirm that sleep never follows the abort.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PS_FULL   = 3'd0,
    PS_DOZE   = 3'd1,
    PS_NAP    = 3'd2,
    PS_HSHAKE = 3'd3,
    PS_SETTLE = 3'd4,
    PS_SLEEP  = 3'd5
  } pwr_state_t;

  typedef enum logic [1:0] {
    MC_FULL  = 2'b00,
    MC_DOZE  = 2'b01,
    MC_NAP   = 2'b10,
    MC_SLEEP = 2'b11
  } mode_code_t;

  typedef struct packed {
    logic doze;
    logic nap;
    logic sleep;
  } mode_sel_t;

endpackage

// File: rtl/pms_mode_decode.sv
module pms_mode_decode
  import pwr_mode_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int DOZE_BIT  = 8,
  parameter int NAP_BIT   = 9,
  parameter int SLEEP_BIT = 10
) (
  input  logic [CFG_W-1:0] cfg,
  output mode_sel_t        sel
);

  localparam logic [CFG_W-1:0] MODE_MASK = (CFG_W'(1) << DOZE_BIT) |
                                           (CFG_W'(1) << NAP_BIT)  |
                                           (CFG_W'(1) << SLEEP_BIT);

  logic d_bit, n_bit, s_bit;
  logic unused_cfg_bits;

  assign d_bit = cfg[DOZE_BIT];
  assign n_bit = cfg[NAP_BIT];
  assign s_bit = cfg[SLEEP_BIT];

  // Bits outside the mode field are deliberately not decoded.
  assign unused_cfg_bits = ^(cfg & ~MODE_MASK);

  // A mode counts only when its bit is the single one set in the field.
  always_comb begin
    sel.doze  = d_bit & ~n_bit & ~s_bit;
    sel.nap   = n_bit & ~d_bit & ~s_bit;
    sel.sleep = s_bit & ~d_bit & ~n_bit;
  end

endmodule

// File: rtl/pms_interval.sv
module pms_interval #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);

  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == W'(1));
  assign cnt_en = start | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = W'(LEN);
    end else if (busy) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_sel_t  sel,
  input  logic       pwr_en,
  input  logic       bus_busy,
  input  logic       qack,
  input  logic       wake,
  input  logic       wake_ok,
  input  logic       settle_last,
  output pwr_state_t state_q,
  output logic       settle_start,
  output logic       relock_start
);

  pwr_state_t state_d;

  always_comb begin
    state_d      = state_q;
    settle_start = 1'b0;
    relock_start = 1'b0;
    unique case (state_q)
      PS_FULL: begin
        // A wake event outranks a pending power-down request.
        if (!wake && pwr_en) begin
          if (sel.doze) begin
            state_d = PS_DOZE;
          end else if (sel.nap && !bus_busy) begin
            state_d = PS_NAP;
          end else if (sel.sleep && !bus_busy) begin
            state_d = PS_HSHAKE;
          end
        end
      end
      PS_DOZE, PS_NAP: begin
        if (wake) state_d = PS_FULL;
      end
      PS_HSHAKE: begin
        if (wake) begin
          state_d = PS_FULL;
        end else if (qack) begin
          state_d      = PS_SETTLE;
          settle_start = 1'b1;
        end
      end
      PS_SETTLE: begin
        if (wake) begin
          state_d = PS_FULL;
        end else if (settle_last) begin
          state_d = PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (wake && wake_ok) begin
          state_d      = PS_FULL;
          relock_start = 1'b1;
        end
      end
      default: state_d = PS_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_FULL;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/pms_gate_ctl.sv
module pms_gate_ctl
  import pwr_mode_pkg::*;
(
  input  pwr_state_t state,
  input  logic       relock_busy,
  output logic       qreq,
  output logic       unit_en,
  output logic       tb_en,
  output logic       l2_ok,
  output mode_code_t code
);

  always_comb begin
    qreq    = 1'b0;
    unit_en = 1'b1;
    tb_en   = 1'b1;
    code    = MC_FULL;
    unique case (state)
      PS_FULL: ;
      PS_DOZE: begin
        unit_en = 1'b0;
        code    = MC_DOZE;
      end
      PS_NAP: begin
        unit_en = 1'b0;
        code    = MC_NAP;
      end
      PS_HSHAKE, PS_SETTLE: begin
        qreq = 1'b1;
      end
      PS_SLEEP: begin
        qreq    = 1'b1;
        unit_en = 1'b0;
        tb_en   = 1'b0;
        code    = MC_SLEEP;
      end
      default: ;
    endcase
    l2_ok = (state != PS_SLEEP) && !relock_busy;
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int CFG_W          = 16,
  parameter int DOZE_BIT       = 8,
  parameter int NAP_BIT        = 9,
  parameter int SLEEP_BIT      = 10,
  parameter int ENTRY_DLY      = 4,
  parameter int RELOCK_CYC     = 640,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_reg,
  input  logic             pwr_en,
  input  logic             bus_busy,
  input  logic             quiesce_ack,
  input  logic             ext_irq,
  input  logic             smi_irq,
  input  logic             pll_stopped,
  input  logic             pll_locked,
  output logic             quiesce_req,
  output logic             unit_clk_en,
  output logic             tb_clk_en,
  output logic             l2_en_ok,
  output logic [1:0]       mode_code
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [RST_SYNC_STAGES-1:0] rst_pipe_q;
  logic                       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[RST_SYNC_STAGES-1];

  mode_sel_t  sel;
  pwr_state_t state;
  mode_code_t code;
  logic       wake, wake_ok;
  logic       settle_start, settle_last, settle_busy;
  logic       relock_start, relock_busy, relock_last;
  logic       unused_tmr;

  assign wake       = ext_irq | smi_irq;
  assign wake_ok    = ~pll_stopped | pll_locked;
  assign unused_tmr = settle_busy ^ relock_last;

  pms_mode_decode #(
    .CFG_W    (CFG_W),
    .DOZE_BIT (DOZE_BIT),
    .NAP_BIT  (NAP_BIT),
    .SLEEP_BIT(SLEEP_BIT)
  ) u_decode (
    .cfg(cfg_reg),
    .sel(sel)
  );

  pms_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .sel         (sel),
    .pwr_en      (pwr_en),
    .bus_busy    (bus_busy),
    .qack        (quiesce_ack),
    .wake        (wake),
    .wake_ok     (wake_ok),
    .settle_last (settle_last),
    .state_q     (state),
    .settle_start(settle_start),
    .relock_start(relock_start)
  );

  pms_interval #(.LEN(ENTRY_DLY)) u_settle (
    .clk  (clk),
    .rst_n(core_rst_n),
    .start(settle_start),
    .busy (settle_busy),
    .last (settle_last)
  );

  pms_interval #(.LEN(RELOCK_CYC)) u_relock (
    .clk  (clk),
    .rst_n(core_rst_n),
    .start(relock_start),
    .busy (relock_busy),
    .last (relock_last)
  );

  pms_gate_ctl u_gate (
    .state      (state),
    .relock_busy(relock_busy),
    .qreq       (quiesce_req),
    .unit_en    (unit_clk_en),
    .tb_en      (tb_clk_en),
    .l2_ok      (l2_en_ok),
    .code       (code)
  );

  assign mode_code = code;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_en,
  input logic       bus_busy,
  input logic       quiesce_ack,
  input logic       ext_irq,
  input logic       smi_irq,
  input logic       pll_stopped,
  input logic       pll_locked,
  input logic       quiesce_req,
  input logic       unit_clk_en,
  input logic       tb_clk_en,
  input logic       l2_en_ok,
  input logic [1:0] mode_code
);

  p_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00 && !quiesce_req && !pwr_en) |=> (mode_code == 2'b00 && !quiesce_req));

  p_qreq_bus_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiesce_req) |-> $past(!bus_busy));

  p_hold_for_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiesce_req && mode_code == 2'b00 && !quiesce_ack && !ext_irq && !smi_irq) |=> quiesce_req);

  p_full_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00) |-> (unit_clk_en && tb_clk_en));

  p_light_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b01 || mode_code == 2'b10) |-> (!unit_clk_en && tb_clk_en && !quiesce_req));

  p_sleep_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b11) |-> (!unit_clk_en && !tb_clk_en && !l2_en_ok && quiesce_req));

  p_wake_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 2'b00 && (ext_irq || smi_irq) && (mode_code != 2'b11 || !pll_stopped || pll_locked))
      |=> (mode_code == 2'b00 && !quiesce_req));

  p_pll_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b11 && pll_stopped && !pll_locked) |=> (mode_code == 2'b11));

  p_relock_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b11) |=> !l2_en_ok);

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (quiesce_req && mode_code == 2'b00 && (ext_irq || smi_irq)) |=> !quiesce_req);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_pwr_mode_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_en     (pwr_en),
  .bus_busy   (bus_busy),
  .quiesce_ack(quiesce_ack),
  .ext_irq    (ext_irq),
  .smi_irq    (smi_irq),
  .pll_stopped(pll_stopped),
  .pll_locked (pll_locked),
  .quiesce_req(quiesce_req),
  .unit_clk_en(unit_clk_en),
  .tb_clk_en  (tb_clk_en),
  .l2_en_ok   (l2_en_ok),
  .mode_code  (mode_code)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

  localparam int ENTRY_DLY  = 4;
  localparam int RELOCK_CYC = 640;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_reg;
  logic        pwr_en, bus_busy, quiesce_ack, ext_irq, smi_irq, pll_stopped, pll_locked;
  logic        quiesce_req, unit_clk_en, tb_clk_en, l2_en_ok;
  logic [1:0]  mode_code;

  always #5 clk = ~clk;

  pwr_mode_seq #(.ENTRY_DLY(ENTRY_DLY), .RELOCK_CYC(RELOCK_CYC)) i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .cfg_reg(cfg_reg), .pwr_en(pwr_en), .bus_busy(bus_busy),
    .quiesce_ack(quiesce_ack), .ext_irq(ext_irq), .smi_irq(smi_irq),
    .pll_stopped(pll_stopped), .pll_locked(pll_locked), .quiesce_req(quiesce_req),
    .unit_clk_en(unit_clk_en), .tb_clk_en(tb_clk_en), .l2_en_ok(l2_en_ok),
    .mode_code(mode_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: 0 full, 1 doze, 2 nap, 3 handshake, 4 settle, 5 sleep.
  int m_st = 0;
  int m_dly = 0;
  int m_relock = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_dly = 0; m_relock = 0;
    end else begin
      bit wk, dz, np, sl, ld;
      wk = ext_irq | smi_irq;
      dz = cfg_reg[8]  && !cfg_reg[9] && !cfg_reg[10];
      np = cfg_reg[9]  && !cfg_reg[8] && !cfg_reg[10];
      sl = cfg_reg[10] && !cfg_reg[8] && !cfg_reg[9];
      ld = 1'b0;
      case (m_st)
        0: if (!wk && pwr_en) begin
             if (dz) m_st = 1;
             else if (np && !bus_busy) m_st = 2;
             else if (sl && !bus_busy) m_st = 3;
           end
        1, 2: if (wk) m_st = 0;
        3: if (wk) m_st = 0;
           else if (quiesce_ack) begin m_st = 4; m_dly = 0; end
        4: if (wk) m_st = 0;
           else begin
             m_dly++;
             if (m_dly == ENTRY_DLY) m_st = 5;
           end
        default: if (wk && (!pll_stopped || pll_locked)) begin m_st = 0; ld = 1'b1; end
      endcase
      if (ld) m_relock = RELOCK_CYC;
      else if (m_relock > 0) m_relock--;
    end
  end

  function automatic int exp_code();
    case (m_st)
      1: return 1;
      2: return 2;
      5: return 3;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R12 mode code vs model", int'(mode_code), exp_code());
      chk("R5 quiesce_req vs model", int'(quiesce_req), (m_st >= 3) ? 1 : 0);
      chk("R7 unit_clk_en vs model", int'(unit_clk_en), (m_st == 0 || m_st == 3 || m_st == 4) ? 1 : 0);
      chk("R7 tb_clk_en vs model", int'(tb_clk_en), (m_st != 5) ? 1 : 0);
      chk("R10 l2_en_ok vs model", int'(l2_en_ok), (m_st != 5 && m_relock == 0) ? 1 : 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_reg = 16'h0000; pwr_en = 1'b0; bus_busy = 1'b0; quiesce_ack = 1'b0;
    ext_irq = 1'b0; smi_irq = 1'b0; pll_stopped = 1'b0; pll_locked = 1'b0;
    cyc(3);
    // R1 reset state
    chk("R1 reset mode", int'(mode_code), 0);
    chk("R1 reset qreq", int'(quiesce_req), 0);
    chk("R1 reset clocks", int'({unit_clk_en, tb_clk_en}), 3);
    chk("R1 reset l2", int'(l2_en_ok), 1);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 after release l2", int'(l2_en_ok), 1);

    // R3: mode chosen but pwr_en low
    cfg_reg = 16'h0400;
    cyc(5);
    chk("R3 no entry without pwr_en", int'({quiesce_req, mode_code}), 0);

    // R2: invalid mode combinations
    pwr_en = 1'b1;
    cfg_reg = 16'h0300; cyc(4);
    chk("R2 doze+nap no entry", int'(mode_code), 0);
    cfg_reg = 16'h0700; cyc(4);
    chk("R2 all bits no entry", int'({quiesce_req, mode_code}), 0);
    cfg_reg = 16'h0000; cyc(4);
    chk("R2 empty field no entry", int'(mode_code), 0);

    // Doze with noise outside the field and bus busy (R2, R4, R7)
    bus_busy = 1'b1;
    cfg_reg = 16'hF1FF; cyc(1);
    chk("R2 doze with other bits set", int'(mode_code), 1);
    chk("R4 doze ignores bus_busy", int'(quiesce_req), 0);
    chk("R7 doze clocks", int'({unit_clk_en, tb_clk_en}), 1);
    pwr_en = 1'b0; ext_irq = 1'b1; cyc(1); ext_irq = 1'b0;
    chk("R8 ext_irq exits doze", int'(mode_code), 0);

    // Nap waits for the bus (R4), smi wakes (R8)
    cfg_reg = 16'h0200; pwr_en = 1'b1; cyc(6);
    chk("R4 nap waits for bus", int'(mode_code), 0);
    bus_busy = 1'b0; cyc(1);
    chk("R12 nap code", int'(mode_code), 2);
    chk("R7 nap clocks", int'({unit_clk_en, tb_clk_en}), 1);
    pwr_en = 1'b0; smi_irq = 1'b1; cyc(1); smi_irq = 1'b0;
    chk("R8 smi_irq exits nap", int'(mode_code), 0);

    // Sleep: drain, handshake, settle, sleep, wake, relock
    cfg_reg = 16'h0400; bus_busy = 1'b1; pwr_en = 1'b1; cyc(5);
    chk("R4 no qreq while bus busy", int'(quiesce_req), 0);
    bus_busy = 1'b0; cyc(1);
    chk("R5 qreq raised", int'(quiesce_req), 1);
    chk("R5 still full while waiting", int'(mode_code), 0);
    cyc(5);
    chk("R5 waits for ack", int'({quiesce_req, mode_code}), 4);
    quiesce_ack = 1'b1; cyc(1); quiesce_ack = 1'b0;
    cyc(3);
    chk("R6 not asleep before interval ends", int'(mode_code), 0);
    cyc(1);
    chk("R6 asleep after interval", int'(mode_code), 3);
    chk("R7 sleep clocks off", int'({unit_clk_en, tb_clk_en}), 0);
    chk("R10 l2 blocked in sleep", int'(l2_en_ok), 0);
    pwr_en = 1'b0; cyc(3);
    chk("R12 sleep held", int'(mode_code), 3);
    ext_irq = 1'b1; cyc(1); ext_irq = 1'b0;
    chk("R8 wake from sleep", int'({quiesce_req, mode_code}), 0);
    chk("R10 l2 blocked after wake", int'(l2_en_ok), 0);
    cyc(RELOCK_CYC - 1);
    chk("R10 l2 blocked on last relock cycle", int'(l2_en_ok), 0);
    cyc(1);
    chk("R10 l2 released after relock", int'(l2_en_ok), 1);

    // R11: wake together with ack aborts
    pwr_en = 1'b1; cyc(1);
    chk("R5 qreq for abort test", int'(quiesce_req), 1);
    pwr_en = 1'b0; quiesce_ack = 1'b1; ext_irq = 1'b1; cyc(1);
    quiesce_ack = 1'b0; ext_irq = 1'b0;
    chk("R11 wake beats ack", int'(quiesce_req), 0);
    cyc(ENTRY_DLY + 2);
    chk("R11 no sleep after abort", int'(mode_code), 0);

    // R11: wake during settle aborts
    pwr_en = 1'b1; cyc(1); pwr_en = 1'b0;
    quiesce_ack = 1'b1; cyc(1); quiesce_ack = 1'b0;
    cyc(1);
    smi_irq = 1'b1; cyc(1); smi_irq = 1'b0;
    chk("R11 wake aborts settle", int'({quiesce_req, mode_code}), 0);
    cyc(ENTRY_DLY + 2);
    chk("R11 no sleep after settle abort", int'(mode_code), 0);

    // R9: PLL stopped, wake held off until lock
    pll_stopped = 1'b1; pll_locked = 1'b0;
    pwr_en = 1'b1; cyc(1); pwr_en = 1'b0;
    quiesce_ack = 1'b1; cyc(1); quiesce_ack = 1'b0;
    cyc(ENTRY_DLY);
    chk("R6 sleep for pll test", int'(mode_code), 3);
    ext_irq = 1'b1; cyc(4);
    chk("R9 wake ignored until lock", int'(mode_code), 3);
    pll_locked = 1'b1; cyc(1);
    chk("R9 wake after lock", int'(mode_code), 0);
    ext_irq = 1'b0; pll_stopped = 1'b0; pll_locked = 1'b0;

    // R11: wake outranks pwr_en at full power
    cfg_reg = 16'h0100; pwr_en = 1'b1; smi_irq = 1'b1; cyc(3);
    chk("R11 wake beats pwr_en", int'(mode_code), 0);
    pwr_en = 1'b0; smi_irq = 1'b0;
    cyc(RELOCK_CYC + 5);
    chk("R10 l2 released at end", int'(l2_en_ok), 1);
    finish_run();
  end

endmodule